// File: doc/BRIEF.md
# Trigger and Fast-Command Sequencer

This block is the timing source of a readout test stand. It keeps a bunch-crossing counter that wraps at a configurable orbit length, and an orbit counter beside it. It marks the start of every orbit and replays a list of physics trigger positions, each an (orbit, bunch crossing) pair, from an external memory. Entries are prefetched into a small queue, and a level-1 accept (L1A) is raised when the counters reach the entry at the head of the queue.

Alongside the triggers it issues one fast broadcast command per cycle at most: bunch-crossing reset, monitoring announcement, resync and event-counter reset. Monitoring triggers recur every few orbits at a programmable crossing. Each one is announced by a command a fixed number of cycles ahead of its L1A. When a physics trigger already sits on the monitoring slot, the monitoring trigger moves to the next orbit.

Every L1A, physics or monitoring, starts a private timer in each of several data-transmitter channels. Each channel pulses its start output once that channel's own latency has elapsed.

Top module: `trig_cmd_seq`

## Requirements
- R1: The crossing counter counts 0 to orbit_len-1 and then returns to 0 while the orbit counter advances by one; an orbit_len of 0 selects an orbit of 3564 crossings.
- R2: orbit_mark is high exactly in the cycles where the crossing counter is 0, and in those cycles the command output carries code 1 (bunch-crossing reset).
- R3: Table entries are read from address 0 upward, n_entries of them. Each entry yields exactly one L1A with l1a_mon low, in the cycle where {orbit_cnt, bx_cnt} equals the entry.
- R4: An entry whose position is already behind the counters when it reaches the head of the queue raises no L1A and increments miss_cnt by one.
- R5: When mon_period is nonzero, a monitoring trigger is armed in every orbit whose index is a multiple of mon_period. Command code 4 is sent at crossing mon_bx-CMD_LEAD (default 2), and an L1A with l1a_mon high follows at crossing mon_bx of the same orbit.
- R6: If a queued physics entry lies at (current orbit, mon_bx) at announcement time, neither the command nor the monitoring L1A is sent in that orbit; both follow in the next orbit.
- R7: A pulse on req_resync or req_ecr is sent as code 3 or code 2 in the first cycle free of higher-priority commands. The order from highest to lowest is code 1, code 4, code 3, code 2.
- R8: For each channel c, start[c] pulses exactly lat[c] cycles after every L1A (lat field c is bits 8c+7..8c), in L1A order, with several starts pending at once.
- R9: While reset is held, both counters are zero, and l1a, start and miss_cnt are low.
- R10: With mon_period equal to 0, no monitoring command and no monitoring L1A is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_len | input | BX_W | Crossings per orbit, 0 selects 3564 |
| n_entries | input | AW | Number of trigger table entries |
| mem_rd | output | 1 | Table read strobe, data expected next cycle |
| mem_addr | output | AW | Table read address |
| mem_orbit | input | ORB_W | Orbit field of the entry read |
| mem_bx | input | BX_W | Crossing field of the entry read |
| mon_period | input | ORB_W | Orbits between monitoring triggers, 0 disables |
| mon_bx | input | BX_W | Crossing of the monitoring L1A |
| req_ecr | input | 1 | Request an event-counter reset command |
| req_resync | input | 1 | Request a resync command |
| lat | input | NCH*LAT_W | Per-channel L1A-to-start latency |
| bx_cnt | output | BX_W | Current crossing |
| orbit_cnt | output | ORB_W | Current orbit |
| orbit_mark | output | 1 | Orbit start marker |
| l1a | output | 1 | Level-1 accept |
| l1a_mon | output | 1 | Current L1A is a monitoring trigger |
| cmd_valid | output | 1 | Fast command present |
| cmd_code | output | 3 | Fast command code (1 BC reset, 2 EC reset, 3 resync, 4 monitor) |
| start | output | NCH | Per-channel transmitter start pulse |
| miss_cnt | output | MISS_W | Count of skipped table entries |

## Verification
The assertions take some things as given. orbit_len and mon_bx stay constant between resets, with mon_bx greater than CMD_LEAD and inside the orbit. Every latency is at least one. No channel holds more than sixteen pending starts. A physics entry at the monitoring slot is already in the prefetch queue when the announcement is due, rather than still in flight from memory. The stimulus sets every configuration before releasing reset. It uses orbits of 40 crossings, or the default length. Tables are short and are prefetched within the first few cycles of a run. At most two L1As are ever pending in a channel.

// File: rtl/trig_cmd_seq.sv
module trig_cmd_seq #(
  parameter int BX_W     = 12,
  parameter int ORB_W    = 16,
  parameter int AW       = 8,
  parameter int FD       = 4,
  parameter int NCH      = 5,
  parameter int QD       = 16,
  parameter int LAT_W    = 8,
  parameter int CMD_LEAD = 2,
  parameter int MISS_W   = 16,
  parameter int DEF_LEN  = 3564
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BX_W-1:0]        orbit_len,
  input  logic [AW-1:0]          n_entries,
  output logic                   mem_rd,
  output logic [AW-1:0]          mem_addr,
  input  logic [ORB_W-1:0]       mem_orbit,
  input  logic [BX_W-1:0]        mem_bx,
  input  logic [ORB_W-1:0]       mon_period,
  input  logic [BX_W-1:0]        mon_bx,
  input  logic                   req_ecr,
  input  logic                   req_resync,
  input  logic [NCH*LAT_W-1:0]   lat,
  output logic [BX_W-1:0]        bx_cnt,
  output logic [ORB_W-1:0]       orbit_cnt,
  output logic                   orbit_mark,
  output logic                   l1a,
  output logic                   l1a_mon,
  output logic                   cmd_valid,
  output logic [2:0]             cmd_code,
  output logic [NCH-1:0]         start,
  output logic [MISS_W-1:0]      miss_cnt
);
  localparam int FAW = $clog2(FD);
  localparam int QAW = $clog2(QD);
  localparam int TW  = LAT_W + 1;
  localparam int PW  = ORB_W + BX_W;
  localparam logic [FAW+1:0] FD_V = (FAW+2)'(FD);
  localparam logic [2:0] C_BCR = 3'd1, C_ECR = 3'd2, C_RSY = 3'd3, C_MON = 3'd4;

  // crossing / orbit counters
  logic [BX_W-1:0] eff_len;
  logic            last;
  assign eff_len    = (orbit_len == '0) ? BX_W'(DEF_LEN) : orbit_len;
  assign last       = (bx_cnt == eff_len - BX_W'(1));
  assign orbit_mark = (bx_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bx_cnt    <= '0;
      orbit_cnt <= '0;
    end else if (last) begin
      bx_cnt    <= '0;
      orbit_cnt <= orbit_cnt + 1'b1;
    end else begin
      bx_cnt    <= bx_cnt + 1'b1;
    end
  end

  // trigger table prefetch queue
  logic [PW-1:0]  fpos [FD];
  logic [FAW-1:0] fwp, frp;
  logic [FAW:0]   fcnt;
  logic           rd_q, hit, late, pop;
  logic [PW-1:0]  now_pos, head;

  assign now_pos = {orbit_cnt, bx_cnt};
  assign head    = fpos[frp];
  assign hit     = (fcnt != '0) && (head == now_pos);
  assign late    = (fcnt != '0) && (head < now_pos);
  assign pop     = hit | late;
  assign mem_rd  = (mem_addr < n_entries) && ((FAW+2)'(fcnt) + (FAW+2)'(rd_q) < FD_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      mem_addr <= '0;
      fwp      <= '0;
      frp      <= '0;
      fcnt     <= '0;
      miss_cnt <= '0;
    end else begin
      rd_q <= mem_rd;
      if (mem_rd) mem_addr <= mem_addr + 1'b1;
      if (rd_q)   fwp <= fwp + 1'b1;
      if (pop)    frp <= frp + 1'b1;
      fcnt <= fcnt + (FAW+1)'(rd_q) - (FAW+1)'(pop);
      if (late)   miss_cnt <= miss_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (rd_q) fpos[fwp] <= {mem_orbit, mem_bx};

  // monitoring triggers
  logic [ORB_W-1:0] mon_div;
  logic             mon_arm, mon_go, coll, announce, mon_fire;

  always_comb begin
    coll = 1'b0;
    for (int i = 0; i < FD; i++)
      if ((FAW+1)'(i) < fcnt && fpos[frp + FAW'(i)] == {orbit_cnt, mon_bx}) coll = 1'b1;
  end

  assign announce = mon_arm && (bx_cnt == mon_bx - BX_W'(CMD_LEAD)) && !coll;
  assign mon_fire = mon_go && (bx_cnt == mon_bx);
  assign l1a      = hit | mon_fire;
  assign l1a_mon  = mon_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_div <= '0;
      mon_arm <= 1'b0;
      mon_go  <= 1'b0;
    end else begin
      if (last) mon_div <= (mon_div + 1'b1 == mon_period) ? '0 : mon_div + 1'b1;
      if (orbit_mark && mon_div == '0 && mon_period != '0) mon_arm <= 1'b1;
      else if (announce) mon_arm <= 1'b0;
      if (announce) mon_go <= 1'b1;
      else if (mon_fire) mon_go <= 1'b0;
    end
  end

  // fast commands
  logic ecr_p, rsy_p;

  always_comb begin
    cmd_valid = 1'b1;
    if (orbit_mark)    cmd_code = C_BCR;
    else if (announce) cmd_code = C_MON;
    else if (rsy_p)    cmd_code = C_RSY;
    else if (ecr_p)    cmd_code = C_ECR;
    else begin
      cmd_valid = 1'b0;
      cmd_code  = 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecr_p <= 1'b0;
      rsy_p <= 1'b0;
    end else begin
      if (req_resync) rsy_p <= 1'b1;
      else if (cmd_code == C_RSY) rsy_p <= 1'b0;
      if (req_ecr) ecr_p <= 1'b1;
      else if (cmd_code == C_ECR) ecr_p <= 1'b0;
    end
  end

  // per-channel latency queues
  logic [TW-1:0] tick;
  always_ff @(posedge clk)
    if (!rst_n) tick <= '0;
    else        tick <= tick + 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TW-1:0]  q [QD];
    logic [QAW-1:0] wp, rp;
    logic [QAW:0]   cnt;
    logic [TW-1:0]  age;
    logic           full, push;

    assign age      = tick - q[rp];
    assign full     = (cnt == (QAW+1)'(QD));
    assign push     = l1a && !full;
    assign start[c] = (cnt != '0) && (age == {1'b0, lat[c*LAT_W +: LAT_W]});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push)     wp <= wp + 1'b1;
        if (start[c]) rp <= rp + 1'b1;
        cnt <= cnt + (QAW+1)'(push) - (QAW+1)'(start[c]);
      end
    end

    always_ff @(posedge clk)
      if (push) q[wp] <= tick;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n) l1a |-> !full);
  end

  p_bx_range_r1:   assert property (@(posedge clk) disable iff (!rst_n) bx_cnt < eff_len);
  p_orbit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
                     last |=> (bx_cnt == '0 && orbit_cnt == $past(orbit_cnt) + 1'b1));
  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) fcnt <= (FAW+1)'(FD));
  p_one_src_r6:    assert property (@(posedge clk) disable iff (!rst_n) !(hit && mon_fire));
  p_mon_cmd_r5:    assert property (@(posedge clk) disable iff (!rst_n)
                     mon_fire |-> $past(cmd_valid && cmd_code == C_MON, CMD_LEAD));
endmodule

// File: tb/trig_cmd_seq_tb.sv
module trig_cmd_seq_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] orbit_len = 12'd40;
  logic [7:0]  n_entries = '0;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic [15:0] mem_orbit = '0;
  logic [11:0] mem_bx = '0;
  logic [15:0] mon_period = '0;
  logic [11:0] mon_bx = 12'd12;
  logic        req_ecr = 1'b0, req_resync = 1'b0;
  logic [39:0] lat = {8'd9, 8'd2, 8'd7, 8'd5, 8'd3};
  logic [11:0] bx_cnt;
  logic [15:0] orbit_cnt;
  logic        orbit_mark, l1a, l1a_mon, cmd_valid;
  logic [2:0]  cmd_code;
  logic [4:0]  start;
  logic [15:0] miss_cnt;

  trig_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .orbit_len(orbit_len), .n_entries(n_entries),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_orbit(mem_orbit), .mem_bx(mem_bx),
    .mon_period(mon_period), .mon_bx(mon_bx), .req_ecr(req_ecr), .req_resync(req_resync),
    .lat(lat), .bx_cnt(bx_cnt), .orbit_cnt(orbit_cnt), .orbit_mark(orbit_mark),
    .l1a(l1a), .l1a_mon(l1a_mon), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .start(start), .miss_cnt(miss_cnt));

  always #(CLK_P/2) clk = ~clk;

  logic [15:0] tab_o [16];
  logic [11:0] tab_b [16];
  always @(posedge clk)
    if (mem_rd) begin
      mem_orbit <= tab_o[mem_addr[3:0]];
      mem_bx    <= tab_b[mem_addr[3:0]];
    end

  int cyc = 0;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  int nchk = 0, nerr = 0;
  int l_cyc [64], l_orb [64], l_bx [64], l_mon [64], nl = 0;
  int c_cyc [64], c_code [64], nc = 0;
  int s_cyc [5][64];
  int ns [5] = '{0, 0, 0, 0, 0};
  bit cnt_chk = 0;
  int lexp = 40;
  int lv [5] = '{3, 5, 7, 2, 9};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (l1a && nl < 64) begin
        l_cyc[nl] = cyc; l_orb[nl] = orbit_cnt; l_bx[nl] = bx_cnt; l_mon[nl] = l1a_mon; nl++;
      end
      if (cmd_valid && nc < 64) begin
        c_cyc[nc] = cyc; c_code[nc] = cmd_code; nc++;
      end
      for (int c = 0; c < 5; c++)
        if (start[c] && ns[c] < 64) begin s_cyc[c][ns[c]] = cyc; ns[c]++; end
      if (cnt_chk) begin
        chk("R1 bx", bx_cnt, cyc % lexp);
        chk("R1 orbit", orbit_cnt, cyc / lexp);
        chk("R2 mark", orbit_mark, (cyc % lexp) == 0);
        if (orbit_mark) chk("R2 bcr code", cmd_code, 1);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    nl = 0; nc = 0;
    for (int c = 0; c < 5; c++) ns[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 bx", bx_cnt, 0);
    chk("R9 orbit", orbit_cnt, 0);
    chk("R9 l1a", l1a, 0);
    chk("R9 start", start, 0);
    chk("R9 miss", miss_cnt, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_counters();
    orbit_len = 12'd40; n_entries = '0; mon_period = '0; lexp = 40;
    do_reset();
    cnt_chk = 1; run_to(130); cnt_chk = 0;
    chk("R2 bcr count", nc, 4);
  endtask

  task automatic t_default_len();
    orbit_len = '0; n_entries = '0; mon_period = '0; lexp = 3564;
    do_reset();
    cnt_chk = 1; run_to(3600); cnt_chk = 0;
    chk("R1 default orbit", orbit_cnt, 1);
    chk("R1 default bx", bx_cnt, 36);
  endtask

  task automatic t_physics();
    int eo [4] = '{0, 0, 1, 2};
    int eb [4] = '{10, 11, 5, 20};
    int ec [4] = '{10, 11, 45, 100};
    tab_o[0] = 0; tab_b[0] = 0;
    tab_o[1] = 0; tab_b[1] = 10;
    tab_o[2] = 0; tab_b[2] = 11;
    tab_o[3] = 1; tab_b[3] = 5;
    tab_o[4] = 1; tab_b[4] = 3;
    tab_o[5] = 2; tab_b[5] = 20;
    orbit_len = 12'd40; n_entries = 8'd6; mon_period = '0;
    do_reset();
    run_to(130);
    chk("R3 l1a count", nl, 4);
    for (int i = 0; i < 4 && i < nl; i++) begin
      chk("R3 l1a orbit", l_orb[i], eo[i]);
      chk("R3 l1a bx", l_bx[i], eb[i]);
      chk("R3 l1a phys", l_mon[i], 0);
    end
    chk("R4 miss count", miss_cnt, 2);
    for (int c = 0; c < 5; c++) begin
      chk("R8 start count", ns[c], 4);
      for (int i = 0; i < 4 && i < ns[c]; i++) chk("R8 start cycle", s_cyc[c][i], ec[i] + lv[c]);
    end
  endtask

  task automatic t_commands();
    orbit_len = 12'd40; n_entries = '0; mon_period = '0;
    do_reset();
    while (cyc != 39) @(negedge clk);
    req_ecr = 1'b1; req_resync = 1'b1;
    @(negedge clk);
    req_ecr = 1'b0; req_resync = 1'b0;
    run_to(60);
    chk("R7 cmd count", nc, 4);
    if (nc >= 4) begin
      chk("R7 bcr first", c_code[1], 1);
      chk("R7 resync cycle", c_cyc[2], 41);
      chk("R7 resync code", c_code[2], 3);
      chk("R7 ecr cycle", c_cyc[3], 42);
      chk("R7 ecr code", c_code[3], 2);
    end
  endtask

  task automatic t_monitor();
    int eo [4] = '{0, 2, 3, 4};
    int em [4] = '{1, 0, 1, 1};
    int ma [3] = '{10, 130, 170};
    int st [4] = '{14, 94, 134, 174};
    int k;
    tab_o[0] = 2; tab_b[0] = 12;
    orbit_len = 12'd40; n_entries = 8'd1; mon_period = 16'd2; mon_bx = 12'd12;
    do_reset();
    run_to(185);
    chk("R5 l1a count", nl, 4);
    for (int i = 0; i < 4 && i < nl; i++) begin
      chk("R6 l1a orbit", l_orb[i], eo[i]);
      chk("R5 l1a bx", l_bx[i], 12);
      chk("R6 l1a kind", l_mon[i], em[i]);
    end
    k = 0;
    for (int i = 0; i < nc; i++)
      if (c_code[i] == 4) begin
        if (k < 3) chk("R5 announce cycle", c_cyc[i], ma[k]);
        k++;
      end
    chk("R6 announce count", k, 3);
    chk("R8 mon start count", ns[3], 4);
    for (int i = 0; i < 4 && i < ns[3]; i++) chk("R8 mon start", s_cyc[3][i], st[i]);
  endtask

  task automatic t_monitor_off();
    int k;
    orbit_len = 12'd40; n_entries = '0; mon_period = '0; mon_bx = 12'd12;
    do_reset();
    run_to(100);
    chk("R10 no l1a", nl, 0);
    k = 0;
    for (int i = 0; i < nc; i++) if (c_code[i] == 4) k++;
    chk("R10 no mon cmd", k, 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual %0d expected 0 (run did not finish)", cyc);
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin tab_o[i] = '0; tab_b[i] = '0; end
    t_counters();
    t_default_len();
    t_physics();
    t_commands();
    t_monitor();
    t_monitor_off();
    report();
  end
endmodule